// File: doc/BRIEF.md
# Paged SRAM Window Controller

This block pages a 512kB SRAM into the memory map of an 8-bit Z80-style machine. The SRAM is split into eight 64kB pages. A page can appear in the Dock bank or in the EXROM bank, and it can cover either the upper 32kB only or the whole 64kB of that bank. A 6-bit configuration register holds the page number, a write-unlock flag, and two window bits. The CPU loads the register through I/O writes. One port address always reaches the register. A second port reaches it only while the SRAM sits in the Dock bank. This lets an external ramdisk cartridge use that second port once the SRAM has moved to EXROM.

After power-on reset the block works as a write-protected 8-page ramdisk in the top half of the Dock bank. This means software written for a 3-bit page plus 1-bit protect ramdisk runs unchanged. Whenever the current window matches the active bank strobe and A15, the block asserts a claim output. The claim disables the internal flash ROM and forces the Dock select seen by the cartridge slots inactive, so the SRAM takes priority. The register is loaded on the system clock edge while an I/O write to a matching port is in progress.

Top module: `sram_window_pager`

## Requirements
- R1: After reset is asserted, the configuration register is 0x00. This means page 0, writes blocked, and a window covering only the upper 32kB of the Dock bank.
- R2: A rising clock edge loads data bits 7, 6, 5 and 2..0 into the register when all of these hold: iorq_n is low, wr_n is low, and cpu_addr[7:0] equals 0x0F. This works in every window mode. If iorq_n is high, or the low address byte differs, the register does not change.
- R3: An I/O write to low byte 0x07 loads the register while register bit 7 is 0. Once bit 7 is 1, such writes are ignored.
- R4: sram_addr[18:16] carries the page number (data bits 2..0). sram_addr[15:0] carries cpu_addr[15:0].
- R5: The window is set by register bit 7 (0 = Dock, 1 = EXROM) and bit 5 (1 = whole 64kB, 0 = upper 32kB only). The SRAM is hit when the strobe of the chosen bank (roscs_n for Dock, exrom_n for EXROM) is low. With bit 5 at 0, A15 must also be 1. The strobe of the other bank never causes a hit.
- R6: Writing any value 0x00–0x07 or 0x40–0x47 produces the upper-32kB Dock window.
- R7: sram_ce_n is low only when the window is hit and mreq_n is low. The claim output follows the window hit regardless of mreq_n.
- R8: sram_we_n is low only when sram_ce_n is low, wr_n is low, and register bit 6 is 1. sram_oe_n is low exactly when sram_ce_n is low and rd_n is low.
- R9: While claim is 1, rom_block is 1 and dock_cs_out_n is held high. Otherwise dock_cs_out_n follows roscs_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous active-high power-on reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU data bus (write data for port cycles) |
| iorq_n | input | 1 | Active-low I/O request |
| mreq_n | input | 1 | Active-low memory request |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| roscs_n | input | 1 | Active-low Dock bank strobe from the host |
| exrom_n | input | 1 | Active-low EXROM bank strobe from the host |
| sram_addr | output | 19 | SRAM address: page above CPU address |
| sram_ce_n | output | 1 | Active-low SRAM chip enable |
| sram_oe_n | output | 1 | Active-low SRAM output enable |
| sram_we_n | output | 1 | Active-low SRAM write enable |
| claim | output | 1 | High while the SRAM owns the current access window |
| rom_block | output | 1 | High to disable the internal flash ROM |
| dock_cs_out_n | output | 1 | Dock select passed on to cartridge slots |

## Verification
The bench builds the block with its defaults: a 3-bit page, a 16-bit CPU address, and port bytes 0x0F and 0x07. These defaults cover all eight pages, both halves of every bank, and both the main and the secondary port. All four window encodings are therefore reachable. The bench pairs each one with the upper and lower CPU half and with the Dock strobe, the EXROM strobe, and the idle bus. With 0x07 as the secondary byte, the bench can write legacy ramdisk values through that port in Dock mode and then show that the same port stops working after the move to EXROM.

// File: rtl/pager_pkg.sv
package pager_pkg;
  localparam int PAGE_W = 3;

  typedef struct packed {
    logic              to_exrom;  // data bit 7
    logic              wr_open;   // data bit 6
    logic              full_bank; // data bit 5
    logic [PAGE_W-1:0] page;      // data bits 2..0
  } pager_cfg_t;

  localparam int CFG_W = $bits(pager_cfg_t);
endpackage

// File: rtl/pager_port_decode.sv
module pager_port_decode #(
  parameter logic [7:0] MAIN_PORT = 8'h0F,
  parameter logic [7:0] ALT_PORT  = 8'h07
) (
  input  logic [7:0] addr_lo,
  input  logic       iorq_n,
  input  logic       wr_n,
  input  logic       alt_allowed,
  output logic       load
);
  logic io_wr, hit_main, hit_alt;

  always_comb begin
    io_wr    = !iorq_n && !wr_n;
    hit_main = io_wr && (addr_lo == MAIN_PORT);
    hit_alt  = io_wr && (addr_lo == ALT_PORT) && alt_allowed;
    load     = hit_main || hit_alt;
  end
endmodule

// File: rtl/pager_cfg_reg.sv
module pager_cfg_reg
  import pager_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] data,
  output pager_cfg_t cfg
);
  pager_cfg_t nxt;

  always_comb begin
    nxt.to_exrom  = data[7];
    nxt.wr_open   = data[6];
    nxt.full_bank = data[5];
    nxt.page      = data[PAGE_W-1:0];
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)       cfg <= '0;
    else if (load) cfg <= nxt;
  end
endmodule

// File: rtl/pager_window.sv
module pager_window
  import pager_pkg::*;
(
  input  pager_cfg_t cfg,
  input  logic       a15,
  input  logic       roscs_n,
  input  logic       exrom_n,
  output logic       hit
);
  logic [2:0] sel;
  logic       bank_on;

  always_comb begin
    sel     = {cfg.to_exrom, cfg.full_bank, a15};
    bank_on = cfg.to_exrom ? !exrom_n : !roscs_n;
    unique case (sel)
      3'b000, 3'b100: hit = 1'b0;
      default:        hit = bank_on;
    endcase
  end
endmodule

// File: rtl/sram_window_pager.sv
module sram_window_pager
  import pager_pkg::*;
#(
  parameter int         CPU_AW    = 16,
  parameter logic [7:0] MAIN_PORT = 8'h0F,
  parameter logic [7:0] ALT_PORT  = 8'h07,
  localparam int        SRAM_AW   = CPU_AW + PAGE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CPU_AW-1:0]  cpu_addr,
  input  logic [7:0]         cpu_data,
  input  logic               iorq_n,
  input  logic               mreq_n,
  input  logic               rd_n,
  input  logic               wr_n,
  input  logic               roscs_n,
  input  logic               exrom_n,
  output logic [SRAM_AW-1:0] sram_addr,
  output logic               sram_ce_n,
  output logic               sram_oe_n,
  output logic               sram_we_n,
  output logic               claim,
  output logic               rom_block,
  output logic               dock_cs_out_n
);
  pager_cfg_t cfg;
  logic       load, hit, ce;

  pager_port_decode #(.MAIN_PORT(MAIN_PORT), .ALT_PORT(ALT_PORT)) u_dec (
    .addr_lo    (cpu_addr[7:0]),
    .iorq_n     (iorq_n),
    .wr_n       (wr_n),
    .alt_allowed(!cfg.to_exrom),
    .load       (load)
  );

  pager_cfg_reg u_cfg (
    .clk (clk),
    .rst (rst),
    .load(load),
    .data(cpu_data),
    .cfg (cfg)
  );

  pager_window u_win (
    .cfg    (cfg),
    .a15    (cpu_addr[CPU_AW-1]),
    .roscs_n(roscs_n),
    .exrom_n(exrom_n),
    .hit    (hit)
  );

  always_comb begin
    ce            = hit && !mreq_n;
    sram_addr     = {cfg.page, cpu_addr};
    sram_ce_n     = !ce;
    sram_oe_n     = !(ce && !rd_n);
    sram_we_n     = !(ce && !wr_n && cfg.wr_open);
    claim         = hit;
    rom_block     = hit;
    dock_cs_out_n = roscs_n || hit;
  end
endmodule

// File: rtl/sram_window_pager_chk.sv
module sram_window_pager_chk
  import pager_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [7:0] addr_lo,
  input logic       iorq_n,
  input logic       mreq_n,
  input logic       wr_n,
  input logic       roscs_n,
  input logic       exrom_n,
  input logic       sram_ce_n,
  input logic       sram_we_n,
  input logic       claim,
  input logic       dock_cs_out_n,
  input pager_cfg_t cfg
);
  assert_ce_needs_mreq_R7: assert property (@(posedge clk) disable iff (rst)
    !sram_ce_n |-> !mreq_n);

  assert_we_qualified_R8: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> (!sram_ce_n && !wr_n && cfg.wr_open));

  assert_claim_hides_dock_R9: assert property (@(posedge clk) disable iff (rst)
    claim |-> dock_cs_out_n);

  assert_alt_port_locked_R3: assert property (@(posedge clk) disable iff (rst)
    (cfg.to_exrom && !iorq_n && !wr_n && addr_lo == 8'h07) |=> $stable(cfg));

  assert_other_strobe_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (claim && roscs_n) |-> cfg.to_exrom);

  assert_no_io_no_change_R2: assert property (@(posedge clk) disable iff (rst)
    iorq_n |=> $stable(cfg));
endmodule

bind sram_window_pager sram_window_pager_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .addr_lo      (cpu_addr[7:0]),
  .iorq_n       (iorq_n),
  .mreq_n       (mreq_n),
  .wr_n         (wr_n),
  .roscs_n      (roscs_n),
  .exrom_n      (exrom_n),
  .sram_ce_n    (sram_ce_n),
  .sram_we_n    (sram_we_n),
  .claim        (claim),
  .dock_cs_out_n(dock_cs_out_n),
  .cfg          (cfg)
);

// File: tb/sram_window_pager_tb.sv
module sram_window_pager_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        iorq_n = 1'b1, mreq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic        roscs_n = 1'b1, exrom_n = 1'b1;
  logic [18:0] sram_addr;
  logic        sram_ce_n, sram_oe_n, sram_we_n, claim, rom_block, dock_cs_out_n;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = !clk;

  sram_window_pager dut_i (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .iorq_n(iorq_n), .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n),
    .roscs_n(roscs_n), .exrom_n(exrom_n), .sram_addr(sram_addr),
    .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
    .claim(claim), .rom_block(rom_block), .dock_cs_out_n(dock_cs_out_n)
  );

  // {cfg[7:0], a15, roscs_n, exrom_n, expected_hit}
  localparam logic [11:0] VEC [16] = '{
    {8'h00, 1'b0, 1'b0, 1'b1, 1'b0},
    {8'h00, 1'b1, 1'b0, 1'b1, 1'b1},
    {8'h00, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'h00, 1'b1, 1'b1, 1'b1, 1'b0},
    {8'h20, 1'b0, 1'b0, 1'b1, 1'b1},
    {8'h20, 1'b1, 1'b0, 1'b1, 1'b1},
    {8'h20, 1'b0, 1'b1, 1'b0, 1'b0},
    {8'h20, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'h80, 1'b0, 1'b1, 1'b0, 1'b0},
    {8'h80, 1'b1, 1'b1, 1'b0, 1'b1},
    {8'h80, 1'b1, 1'b0, 1'b1, 1'b0},
    {8'h80, 1'b0, 1'b0, 1'b1, 1'b0},
    {8'hA0, 1'b0, 1'b1, 1'b0, 1'b1},
    {8'hA0, 1'b1, 1'b1, 1'b0, 1'b1},
    {8'hA0, 1'b0, 1'b0, 1'b1, 1'b0},
    {8'hA0, 1'b1, 1'b1, 1'b1, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_bus();
    iorq_n = 1'b1; mreq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    roscs_n = 1'b1; exrom_n = 1'b1;
  endtask

  task automatic io_write(input logic [7:0] port, input logic [7:0] val, input logic use_iorq);
    @(negedge clk);
    idle_bus();
    cpu_addr = {8'h12, port}; cpu_data = val;
    iorq_n = !use_iorq; wr_n = 1'b0;
    @(negedge clk);
    idle_bus();
  endtask

  // memory access; values settle combinationally, sampled 1 ns later
  task automatic mem_cycle(input logic a15, input logic rs_n, input logic ex_n,
                           input logic wr, input logic mreq);
    @(negedge clk);
    cpu_addr = {a15, 15'h1234};
    roscs_n = rs_n; exrom_n = ex_n;
    mreq_n = !mreq; iorq_n = 1'b1;
    rd_n = wr; wr_n = !wr;
    #1;
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state - page 0, protected, top dock only
    mem_cycle(1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    check("R1 upper dock hit", {31'b0, sram_ce_n}, 32'h0);
    check("R1 page zero", {29'b0, sram_addr[18:16]}, 32'h0);
    check("R1 write blocked", {31'b0, sram_we_n}, 32'h1);
    mem_cycle(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    check("R1 lower dock not hit", {31'b0, claim}, 32'h0);

    // R5/R9/R8 window table sweep through main port
    foreach (VEC[i]) begin
      io_write(8'h0F, VEC[i][11:4], 1'b1);
      mem_cycle(VEC[i][3], VEC[i][2], VEC[i][1], 1'b0, 1'b1);
      check($sformatf("R5 vec%0d claim", i), {31'b0, claim}, {31'b0, VEC[i][0]});
      check($sformatf("R9 vec%0d rom_block", i), {31'b0, rom_block}, {31'b0, VEC[i][0]});
      check($sformatf("R9 vec%0d dock_out", i), {31'b0, dock_cs_out_n},
            {31'b0, VEC[i][0] | VEC[i][2]});
      check($sformatf("R8 vec%0d oe", i), {31'b0, sram_oe_n}, {31'b0, !VEC[i][0]});
    end

    // R3/R4/R6: legacy value 0x45 through alternate port in dock mode
    io_write(8'h0F, 8'h00, 1'b1);
    io_write(8'h07, 8'h45, 1'b1);
    mem_cycle(1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    check("R3 alt port loads page", {29'b0, sram_addr[18:16]}, 32'h5);
    check("R4 low address passthrough", {16'b0, sram_addr[15:0]}, 32'h9234);
    check("R8 unlocked write", {31'b0, sram_we_n}, 32'h0);
    mem_cycle(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    check("R6 0x45 lower half empty", {31'b0, claim}, 32'h0);

    // R6: 0x07 gives top dock, protected, page 7
    io_write(8'h0F, 8'h07, 1'b1);
    mem_cycle(1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    check("R6 0x07 page", {29'b0, sram_addr[18:16]}, 32'h7);
    check("R6 0x07 protected", {31'b0, sram_we_n}, 32'h1);
    check("R6 0x07 upper dock hit", {31'b0, sram_ce_n}, 32'h0);

    // R7: no MREQ -> no chip enable, claim still on
    mem_cycle(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R7 ce needs mreq", {31'b0, sram_ce_n}, 32'h1);
    check("R7 claim without mreq", {31'b0, claim}, 32'h1);

    // R3: alternate port ignored after move to EXROM
    io_write(8'h0F, 8'h82, 1'b1);
    io_write(8'h07, 8'h25, 1'b1);
    mem_cycle(1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R3 alt ignored lower half", {31'b0, claim}, 32'h0);
    mem_cycle(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R3 alt ignored page", {29'b0, sram_addr[18:16]}, 32'h2);
    check("R3 still exrom window", {31'b0, claim}, 32'h1);

    // R2: main port works in EXROM mode; write without IORQ and wrong port ignored
    io_write(8'h0F, 8'hE3, 1'b1);
    io_write(8'h0F, 8'h01, 1'b0);
    io_write(8'h1F, 8'h01, 1'b1);
    mem_cycle(1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    check("R2 main port in exrom mode page", {29'b0, sram_addr[18:16]}, 32'h3);
    check("R2 ignored writes keep window", {31'b0, sram_ce_n}, 32'h0);
    check("R8 write open", {31'b0, sram_we_n}, 32'h0);

    // R1: reset again clears register
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    mem_cycle(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R1 reset leaves exrom", {31'b0, claim}, 32'h0);

    idle_bus();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule